// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits on the write path of a flash bank. It watches each bus write cycle, which carries an address and a data word, and recognises the keyed unlock sequences that guard every change to the array. Each time a sequence completes, the block emits a single-clock request to the operation engine. A request can be word program (with target address and data word), chip erase, sector erase or block erase (with the final-cycle address), erase-suspend or erase-resume. Identification mode can also be switched on and off. While that mode is on, the block returns the fixed identification words on its read port.

The operation engine reports three status bits. The first says a program or chip erase is running. The second says a sector or block erase is running. The third says an erase is suspended; with it the engine gives the suspended address and whether that region is a block or a sector. The set of writes the block accepts depends on these bits. A write is a key cycle when its data low byte is AAh and its address bits 11..0 are 555h. A write is a confirm cycle when its low byte is 55h and its address bits 11..0 are 2AAh.

The sequencer has seven states:
- IDLE: no keys have been seen.
- KEY1: a key cycle was seen.
- KEY2: a key then a confirm cycle were seen.
- PDATA: waiting for the program target.
- EKEY3: the erase code was seen.
- EKEY4: a second key cycle after the erase code was seen.
- ESEL: a second confirm was seen; waiting for the erase selector.

The transitions are:
- IDLE to KEY1 on a key cycle.
- KEY1 to KEY2 on a confirm cycle.
- KEY2 to PDATA on A0h at 555h.
- KEY2 to EKEY3 on 80h at 555h.
- KEY2 to IDLE with an ID-on request on 90h at 555h.
- EKEY3 to EKEY4 on a key cycle.
- EKEY4 to ESEL on a confirm cycle.
- ESEL to IDLE with an erase request.
- PDATA to IDLE with a program request.
- Any state to IDLE on a mismatch, on F0h (exit), or while the engine is busy.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the sequencer is in IDLE, every request output is 0, id_mode is 0 and id_data is 0000h.
- R2: Command cycles compare only address bits 11..0 and data bits 7..0. Address bits above 11 and data bits 15..8 never change which command is decoded.
- R3: The sequence AAh@555h, 55h@2AAh, A0h@555h, followed by any fourth write, raises req_program for exactly the clock after the fourth write. In that same clock, req_addr and req_data hold the full address and data word of the fourth write.
- R4: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh is followed by a sixth write that selects the erase:
  - 10h at 555h raises req_chip_erase.
  - 30h at any address raises req_sector_erase.
  - 50h at any address raises req_block_erase.
  The request is issued on the clock after the sixth write, with req_addr equal to that write's address.
- R5: AAh@555h, 55h@2AAh, 90h@555h pulses req_id_enter and sets id_mode on the clock after the third write.
- R6: With id_mode set, id_data is 00BFh when rd_addr bits 19..18 are 0 and bits 17..0 equal 0. It is 734Bh when bits 19..18 are 0 and bits 17..0 equal 1. It is 0000h otherwise. With id_mode clear, id_data is always 0000h.
- R7: A write with low byte F0h, at any address and in any state except PDATA, pulses req_id_exit, clears id_mode and returns to IDLE. This covers both the single-write exit and the three-cycle exit.
- R8: A write that does not match the expected next cycle returns the sequencer to IDLE without a request. The following write is then decoded as a first cycle.
- R9: While busy_pgm is 1, every write is ignored, including ID entry and exit, and the sequencer is held in IDLE. Any partly entered sequence is lost.
- R10: While busy_erase is 1 and suspended is 0, only a write with low byte B0h has an effect: it pulses req_suspend. The sequencer is held in IDLE.
- R11: While suspended is 1, a write with low byte 30h received in IDLE pulses req_resume. An erase selector in ESEL is discarded without a request.
- R12: While suspended is 1, a program request is discarded when its target lies in the suspended region. The region is address bits 19..15 when susp_block is 1 and bits 19..11 otherwise. Targets outside the region are issued.
- R13: Every request is a single-clock pulse. At most one request is active in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One bus write cycle to the flash bank this clock |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data word |
| busy_pgm | input | 1 | Program or chip erase in progress |
| busy_erase | input | 1 | Sector or block erase in progress |
| suspended | input | 1 | Erase is suspended |
| susp_addr | input | 20 | Address of the suspended erase |
| susp_block | input | 1 | Suspended erase covers a block (1) or a sector (0) |
| rd_addr | input | 20 | Read address for identification data |
| req_program | output | 1 | Program request pulse |
| req_chip_erase | output | 1 | Chip erase request pulse |
| req_sector_erase | output | 1 | Sector erase request pulse |
| req_block_erase | output | 1 | Block erase request pulse |
| req_suspend | output | 1 | Erase-suspend request pulse |
| req_resume | output | 1 | Erase-resume request pulse |
| req_id_enter | output | 1 | ID-mode entry pulse |
| req_id_exit | output | 1 | ID-mode exit pulse |
| req_addr | output | 20 | Address of the completing write |
| req_data | output | 16 | Data word of the completing write |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 16 | Identification read data |

## Verification
The bench drives key cycles with random upper address bits and random high data bytes. A decoder that compares too many bits would then drop valid commands. It injects mismatches partway through a sequence and holds the engine busy partway through one. A sequencer that is not forced back to IDLE would then issue a program from a later lone A0h write. It also checks that F0h written as program data is treated as data and not as an exit. In the suspended state it aims program targets both inside and just outside the suspended sector or block, and sends erase selectors. A wrong region compare would corrupt the region under erase; a missing guard would start a second erase.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int KEY_ADDR_W = 12;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_A = 12'h555;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_B = 12'h2AA;

    localparam logic [7:0] CODE_KEY1   = 8'hAA;
    localparam logic [7:0] CODE_KEY2   = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ERASE  = 8'h80;
    localparam logic [7:0] CODE_ID_ON  = 8'h90;
    localparam logic [7:0] CODE_ID_OFF = 8'hF0;
    localparam logic [7:0] CODE_CHIP   = 8'h10;
    localparam logic [7:0] CODE_SECT   = 8'h30;
    localparam logic [7:0] CODE_BLK    = 8'h50;
    localparam logic [7:0] CODE_SUSP   = 8'hB0;
    localparam logic [7:0] CODE_RESUME = 8'h30;

    localparam logic [15:0] ID_WORD_MAKER = 16'h00BF;
    localparam logic [15:0] ID_WORD_PART  = 16'h734B;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PDATA,
        ST_EKEY3,
        ST_EKEY4,
        ST_ESEL
    } seq_state_t;

    localparam int N_REQ = 9;

    typedef enum logic [3:0] {
        RQ_NONE,
        RQ_PROG,
        RQ_CHIP,
        RQ_SECT,
        RQ_BLK,
        RQ_SUSP,
        RQ_RESUME,
        RQ_ID_ON,
        RQ_ID_OFF
    } req_kind_t;

    typedef struct packed {
        logic       key1;
        logic       key2;
        logic       at_a;
        logic [7:0] code;
    } bus_key_t;

endpackage

// File: rtl/fcd_key_match.sv
module fcd_key_match
    import fcd_pkg::*;
(
    input  logic [KEY_ADDR_W-1:0] addr_lo,
    input  logic [7:0]            data_lo,
    output bus_key_t              key
);
    logic at_a;
    logic at_b;

    always_comb begin
        at_a     = (addr_lo == KEY_ADDR_A);
        at_b     = (addr_lo == KEY_ADDR_B);
        key.at_a = at_a;
        key.code = data_lo;
        key.key1 = at_a && (data_lo == CODE_KEY1);
        key.key2 = at_b && (data_lo == CODE_KEY2);
    end
endmodule

// File: rtl/fcd_region_guard.sv
module fcd_region_guard #(
    parameter int HI_W      = 9,
    parameter int BLK_SHIFT = 4
) (
    input  logic            suspended,
    input  logic            susp_block,
    input  logic [HI_W-1:0] susp_hi,
    input  logic [HI_W-1:0] tgt_hi,
    output logic            blocked
);
    localparam int BLK_W = HI_W - BLK_SHIFT;

    logic same_sector;
    logic same_block;

    always_comb begin
        same_sector = (tgt_hi == susp_hi);
        same_block  = (tgt_hi[HI_W-1 -: BLK_W] == susp_hi[HI_W-1 -: BLK_W]);
        blocked     = suspended && (susp_block ? same_block : same_sector);
    end
endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int BANK_W = 2
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] id_data
);
    localparam int OFS_W = ADDR_W - BANK_W;

    logic [BANK_W-1:0] bank;
    logic [OFS_W-1:0]  ofs;

    always_comb begin
        bank    = rd_addr[ADDR_W-1 -: BANK_W];
        ofs     = rd_addr[OFS_W-1:0];
        id_data = '0;
        if (id_mode && bank == '0) begin
            if (ofs == OFS_W'(0))
                id_data = DATA_W'(ID_WORD_MAKER);
            else if (ofs == OFS_W'(1))
                id_data = DATA_W'(ID_WORD_PART);
        end
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_valid,
    input  bus_key_t  key,
    input  logic      busy_pgm,
    input  logic      erase_run,
    input  logic      suspended,
    input  logic      blocked,
    output req_kind_t kind_d
);
    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        kind_d  = RQ_NONE;
        if (busy_pgm) begin
            state_d = ST_IDLE;
        end else if (erase_run) begin
            state_d = ST_IDLE;
            if (wr_valid && key.code == CODE_SUSP)
                kind_d = RQ_SUSP;
        end else if (wr_valid) begin
            state_d = ST_IDLE;
            if (state_q == ST_PDATA) begin
                if (!blocked)
                    kind_d = RQ_PROG;
            end else if (key.code == CODE_ID_OFF) begin
                kind_d = RQ_ID_OFF;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (key.key1)
                            state_d = ST_KEY1;
                        else if (suspended && key.code == CODE_RESUME)
                            kind_d = RQ_RESUME;
                    end
                    ST_KEY1: begin
                        if (key.key2)
                            state_d = ST_KEY2;
                    end
                    ST_KEY2: begin
                        if (key.at_a) begin
                            if (key.code == CODE_PROG)
                                state_d = ST_PDATA;
                            else if (key.code == CODE_ERASE)
                                state_d = ST_EKEY3;
                            else if (key.code == CODE_ID_ON)
                                kind_d = RQ_ID_ON;
                        end
                    end
                    ST_EKEY3: begin
                        if (key.key1)
                            state_d = ST_EKEY4;
                    end
                    ST_EKEY4: begin
                        if (key.key2)
                            state_d = ST_ESEL;
                    end
                    ST_ESEL: begin
                        if (!suspended) begin
                            if (key.at_a && key.code == CODE_CHIP)
                                kind_d = RQ_CHIP;
                            else if (key.code == CODE_SECT)
                                kind_d = RQ_SECT;
                            else if (key.code == CODE_BLK)
                                kind_d = RQ_BLK;
                        end
                    end
                    ST_PDATA: begin
                        state_d = ST_IDLE;
                    end
                    default: begin
                        state_d = ST_IDLE;
                    end
                endcase
            end
        end
    end

    // R9 R10
    held_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_pgm || erase_run) |-> state_q == ST_IDLE);

    // R3
    pdata_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PDATA |-> $past(state_q) == ST_KEY2 || $past(state_q) == ST_PDATA);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15,
    parameter int BANK_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy_pgm,
    input  logic              busy_erase,
    input  logic              suspended,
    input  logic [ADDR_W-1:0] susp_addr,
    input  logic              susp_block,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              req_program,
    output logic              req_chip_erase,
    output logic              req_sector_erase,
    output logic              req_block_erase,
    output logic              req_suspend,
    output logic              req_resume,
    output logic              req_id_enter,
    output logic              req_id_exit,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic              id_mode,
    output logic [DATA_W-1:0] id_data
);
    localparam int HI_W      = ADDR_W - SECT_LSB;
    localparam int BLK_SHIFT = BLK_LSB - SECT_LSB;

    bus_key_t          key;
    logic              erase_run;
    logic              blocked;
    req_kind_t         kind_d;
    req_kind_t         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              id_q;
    logic [N_REQ-1:0]  req_vec;

    assign erase_run = busy_erase && !suspended;

    fcd_key_match u_match (
        .addr_lo (wr_addr[KEY_ADDR_W-1:0]),
        .data_lo (wr_data[7:0]),
        .key     (key)
    );

    fcd_region_guard #(
        .HI_W      (HI_W),
        .BLK_SHIFT (BLK_SHIFT)
    ) u_guard (
        .suspended  (suspended),
        .susp_block (susp_block),
        .susp_hi    (susp_addr[ADDR_W-1:SECT_LSB]),
        .tgt_hi     (wr_addr[ADDR_W-1:SECT_LSB]),
        .blocked    (blocked)
    );

    fcd_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .key       (key),
        .busy_pgm  (busy_pgm),
        .erase_run (erase_run),
        .suspended (suspended),
        .blocked   (blocked),
        .kind_d    (kind_d)
    );

    fcd_id_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BANK_W (BANK_W)
    ) u_id (
        .id_mode (id_q),
        .rd_addr (rd_addr),
        .id_data (id_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= RQ_NONE;
            addr_q <= '0;
            data_q <= '0;
            id_q   <= 1'b0;
        end else begin
            kind_q <= kind_d;
            if (kind_d != RQ_NONE) begin
                addr_q <= wr_addr;
                data_q <= wr_data;
            end
            if (kind_d == RQ_ID_ON)
                id_q <= 1'b1;
            else if (kind_d == RQ_ID_OFF)
                id_q <= 1'b0;
        end
    end

    for (genvar k = 0; k < N_REQ; k++) begin : g_req
        assign req_vec[k] = (kind_q == req_kind_t'(k));
    end

    assign req_program      = req_vec[RQ_PROG];
    assign req_chip_erase   = req_vec[RQ_CHIP];
    assign req_sector_erase = req_vec[RQ_SECT];
    assign req_block_erase  = req_vec[RQ_BLK];
    assign req_suspend      = req_vec[RQ_SUSP];
    assign req_resume       = req_vec[RQ_RESUME];
    assign req_id_enter     = req_vec[RQ_ID_ON];
    assign req_id_exit      = req_vec[RQ_ID_OFF];
    assign req_addr         = addr_q;
    assign req_data         = data_q;
    assign id_mode          = id_q;

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_pgm) |-> !(req_program || req_chip_erase || req_sector_erase ||
            req_block_erase || req_suspend || req_resume || req_id_enter || req_id_exit));

    // R12
    susp_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_program && $past(suspended) |->
            ($past(susp_block) ? ((req_addr >> BLK_LSB) != ($past(susp_addr) >> BLK_LSB))
                               : ((req_addr >> SECT_LSB) != ($past(susp_addr) >> SECT_LSB))));

    // R5
    id_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> req_id_enter);

    // R7
    id_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(id_mode) |-> req_id_exit);

    // R10
    suspend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_suspend |-> $past(busy_erase && !suspended && !busy_pgm && wr_valid));

    // R13
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_program |=> !req_program);

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy_pgm = 1'b0;
    logic        busy_erase = 1'b0;
    logic        suspended = 1'b0;
    logic [19:0] susp_addr = '0;
    logic        susp_block = 1'b0;
    logic [19:0] rd_addr = '0;
    logic        req_program, req_chip_erase, req_sector_erase, req_block_erase;
    logic        req_suspend, req_resume, req_id_enter, req_id_exit;
    logic [19:0] req_addr;
    logic [15:0] req_data;
    logic        id_mode;
    logic [15:0] id_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_state = 0;
    bit m_id    = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy_pgm(busy_pgm), .busy_erase(busy_erase),
        .suspended(suspended), .susp_addr(susp_addr), .susp_block(susp_block),
        .rd_addr(rd_addr), .req_program(req_program), .req_chip_erase(req_chip_erase),
        .req_sector_erase(req_sector_erase), .req_block_erase(req_block_erase),
        .req_suspend(req_suspend), .req_resume(req_resume), .req_id_enter(req_id_enter),
        .req_id_exit(req_id_exit), .req_addr(req_addr), .req_data(req_data),
        .id_mode(id_mode), .id_data(id_data)
    );

    function automatic int act_kind();
        int n = 0;
        int k = 0;
        if (req_program)      begin n++; k = 1; end
        if (req_chip_erase)   begin n++; k = 2; end
        if (req_sector_erase) begin n++; k = 3; end
        if (req_block_erase)  begin n++; k = 4; end
        if (req_suspend)      begin n++; k = 5; end
        if (req_resume)       begin n++; k = 6; end
        if (req_id_enter)     begin n++; k = 7; end
        if (req_id_exit)      begin n++; k = 8; end
        return (n > 1) ? 15 : k;
    endfunction

    function automatic string tag_of(int k);
        case (k)
            1: return "R3";
            2, 3, 4: return "R4";
            5: return "R10";
            6: return "R11";
            7: return "R5";
            8: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic bit in_region(logic [19:0] a);
        return susp_block ? (a[19:15] == susp_addr[19:15]) : (a[19:11] == susp_addr[19:11]);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(logic [19:0] a, logic [15:0] d, output int ek);
        bit ha = (a[11:0] == 12'h555);
        bit hb = (a[11:0] == 12'h2AA);
        logic [7:0] c = d[7:0];
        int s;
        ek = 0;
        if (busy_pgm) m_state = 0;
        else if (busy_erase && !suspended) begin
            m_state = 0;
            if (c == 8'hB0) ek = 5;
        end else if (m_state == 3) begin
            m_state = 0;
            if (!(suspended && in_region(a))) ek = 1;
        end else if (c == 8'hF0) begin
            m_state = 0; ek = 8; m_id = 1'b0;
        end else begin
            s = m_state;
            m_state = 0;
            case (s)
                0: if (ha && c == 8'hAA) m_state = 1;
                   else if (suspended && c == 8'h30) ek = 6;
                1: if (hb && c == 8'h55) m_state = 2;
                2: if (ha) begin
                       if (c == 8'hA0) m_state = 3;
                       else if (c == 8'h80) m_state = 4;
                       else if (c == 8'h90) begin ek = 7; m_id = 1'b1; end
                   end
                4: if (ha && c == 8'hAA) m_state = 5;
                5: if (hb && c == 8'h55) m_state = 6;
                6: if (!suspended) begin
                       if (ha && c == 8'h10) ek = 2;
                       else if (c == 8'h30) ek = 3;
                       else if (c == 8'h50) ek = 4;
                   end
                default: ;
            endcase
        end
    endtask

    task automatic wr(logic [19:0] a, logic [15:0] d);
        int ek;
        int ak;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        model(a, d, ek);
        @(negedge clk);
        wr_valid = 1'b0;
        ak = act_kind();
        check(ak == ek, tag_of(ek), "request kind", ak, ek);
        if (ek >= 1 && ek <= 4 && ak == ek)
            check(req_addr == a, tag_of(ek), "req_addr", int'(req_addr), int'(a));
        if (ek == 1 && ak == 1)
            check(req_data == d, "R3", "req_data", int'(req_data), int'(d));
        check(id_mode == m_id, "R5", "id_mode", int'(id_mode), int'(m_id));
        @(negedge clk);
        ak = act_kind();
        check(ak == 0, "R13", "pulse width", ak, 0);
    endtask

    task automatic set_status(bit bp, bit be, bit su, logic [19:0] sa, bit sb);
        @(negedge clk);
        busy_pgm = bp; busy_erase = be; suspended = su; susp_addr = sa; susp_block = sb;
        if (bp || (be && !su)) m_state = 0;
    endtask

    task automatic id_read(logic [19:0] a, logic [15:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(id_data == exp, "R6", "id_data", int'(id_data), int'(exp));
    endtask

    function automatic logic [19:0] up(logic [11:0] lo);
        return {8'($urandom), lo};
    endfunction

    function automatic logic [15:0] dv(logic [7:0] lo);
        return {8'($urandom), lo};
    endfunction

    task automatic unlock2();
        wr(up(12'h555), dv(8'hAA));
        wr(up(12'h2AA), dv(8'h55));
    endtask

    task automatic full_seq(int kind, logic [19:0] a, logic [15:0] d);
        unlock2();
        case (kind)
            0: begin wr(up(12'h555), dv(8'hA0)); wr(a, d); end
            1: wr(up(12'h555), dv(8'h90));
            2: wr(up(12'h555), dv(8'hF0));
            default: begin
                wr(up(12'h555), dv(8'h80));
                unlock2();
                if (kind == 3) wr(up(12'h555), dv(8'h10));
                else if (kind == 4) wr(a, dv(8'h30));
                else wr(a, dv(8'h50));
            end
        endcase
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [19:0] a;
        logic [15:0] d;
        int ak;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        ak = act_kind();
        check(ak == 0, "R1", "requests after reset", ak, 0);
        check(id_mode == 1'b0, "R1", "id_mode after reset", int'(id_mode), 0);
        check(id_data == 16'h0, "R1", "id_data after reset", int'(id_data), 0);

        // R2 R3 program with upper address bits and high data byte set
        wr(20'hFF555, 16'hC3AA);
        wr(20'h3A2AA, 16'h7E55);
        wr(20'h81555, 16'h12A0);
        wr(20'h5ABCD, 16'hBEEF);
        // F0 as program data is data, not exit
        full_seq(0, 20'h01234, 16'h00F0);

        // R4 erases
        full_seq(3, 20'h0, 16'h0);
        full_seq(4, 20'h47800, 16'h0);
        full_seq(5, 20'hC8000, 16'h0);

        // R5 R6 R7 id mode
        full_seq(1, 20'h0, 16'h0);
        id_read(20'h00000, 16'h00BF);
        id_read(20'h00001, 16'h734B);
        id_read(20'h00002, 16'h0000);
        id_read(20'h40000, 16'h0000);
        wr(20'h9ABCD, 16'h44F0);
        id_read(20'h00000, 16'h0000);
        full_seq(1, 20'h0, 16'h0);
        full_seq(2, 20'h0, 16'h0);
        id_read(20'h00001, 16'h0000);

        // R8 aborts
        wr(up(12'h555), dv(8'hAA));
        wr(up(12'h2AA), dv(8'h55));
        wr(up(12'h555), dv(8'h77));
        wr(up(12'h555), dv(8'hA0));
        wr(up(12'h555), dv(8'hAA));
        wr(up(12'h555), dv(8'hAA));
        full_seq(0, 20'h00777, 16'h5555);

        // R9 busy program: partial sequence lost, ID commands ignored
        unlock2();
        set_status(1, 0, 0, 20'h0, 0);
        wr(up(12'h555), dv(8'hF0));
        full_seq(1, 20'h0, 16'h0);
        set_status(0, 0, 0, 20'h0, 0);
        wr(up(12'h555), dv(8'hA0));
        wr(20'h11111, 16'h2222);

        // R10 erase running
        set_status(0, 1, 0, 20'h23000, 0);
        wr(20'h00000, 16'h00B0);
        wr(up(12'h555), dv(8'hAA));
        wr(up(12'h555), dv(8'hF0));

        // R11 R12 suspended sector at 23000h
        set_status(0, 1, 1, 20'h23000, 0);
        wr(20'h76543, 16'h0030);
        full_seq(3, 20'h0, 16'h0);
        full_seq(0, 20'h237FF, 16'h1111);
        full_seq(0, 20'h23800, 16'h2222);
        set_status(0, 1, 1, 20'h23000, 1);
        full_seq(0, 20'h27FFF, 16'h3333);
        full_seq(0, 20'h28000, 16'h4444);
        set_status(0, 0, 0, 20'h0, 0);

        // random phase
        for (int i = 0; i < 2500; i++) begin
            if (i % 20 == 0) begin
                int mode = int'($urandom % 8);
                set_status(mode == 4, mode == 5 || mode >= 6, mode >= 6,
                           20'($urandom), 1'($urandom));
            end
            if ($urandom % 4 == 0) begin
                int kind = int'($urandom % 6);
                if ($urandom % 2 == 0) a = {susp_addr[19:11], 11'($urandom)};
                else a = 20'($urandom);
                full_seq(kind, a, 16'($urandom));
            end else begin
                int r = int'($urandom % 12);
                case (r)
                    0: begin a = up(12'h555); d = dv(8'hAA); end
                    1: begin a = up(12'h2AA); d = dv(8'h55); end
                    2: begin a = up(12'h555); d = dv(8'hA0); end
                    3: begin a = up(12'h555); d = dv(8'h80); end
                    4: begin a = up(12'h555); d = dv(8'h90); end
                    5: begin a = up(12'h555); d = dv(8'hF0); end
                    6: begin a = up(12'h555); d = dv(8'h10); end
                    7: begin a = 20'($urandom); d = dv(8'h30); end
                    8: begin a = 20'($urandom); d = dv(8'h50); end
                    9: begin a = 20'($urandom); d = dv(8'hB0); end
                    10: begin a = 20'($urandom); d = 16'($urandom); end
                    default: begin a = {susp_addr[19:11], 11'($urandom)}; d = 16'($urandom); end
                endcase
                wr(a, d);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule